// File: doc/BRIEF.md
# Read-Path Stuck-At Fault Injector

This block sits on the read-data return path between a bus and a memory self-test engine. It lets a designer prove that the self-test logic really catches a stuck-at defect. When injection is enabled and the address of a read matches a programmed word address, one chosen bit of the returned 32-bit word is forced to 0 or to 1. All other bits pass through unchanged. An always-match mode applies the fault to every read.

Two configuration words set the fault. The control word holds the mode, address mask, fault type and bit index. The match word holds the target word address. Both accept writes only while the injection-enable input is high. They have no reset, so software must clear them before use.

The byte address is captured when a read request is issued. The later returned data is then judged against the address it belongs to.

Top module: `rd_fault_injector`

## Requirements
- R1: While `injEnable` is 0, `rspDataOut` equals `rspDataIn` in every bit, whatever the configuration.
- R2: Control word layout: bit 0 is always-match, bit 1 is the fault type, bits [6:2] are the bit index and bits [30:7] are the 24-bit mask. `cfgSel`=0 writes the control word. `cfgSel`=1 writes the match word, which is taken from `cfgWrData[29:0]`. With always-match set and `injEnable` high, the fault applies to every captured address.
- R3: With always-match clear, the fault applies only when captured byte address bits [31:2] equal the match word in every bit not masked. A differing word address passes the data through.
- R4: A 1 in mask bit x makes byte address bit x+2 a don't-care. Byte address bits [31:26] are always compared, because the mask is zero-extended at the top.
- R5: A fault type of 0 forces the indexed bit to 0. A fault type of 1 forces it to 1.
- R6: Only the bit selected by the index can differ between `rspDataOut` and `rspDataIn`.
- R7: A configuration write made while `injEnable` is 0 leaves both configuration words unchanged.
- R8: The address used for matching is `reqAddr` sampled at the clock edge where `reqValid` is 1. It is held until the next request and is cleared to 0 by reset.
- R9: The configuration words are not affected by reset and keep their last written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the captured request address |
| injEnable | input | 1 | Injection enable; also unlocks configuration writes |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | 0 selects the control word, 1 selects the match word |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | 1 | Read request issued this cycle |
| reqAddr | input | 32 | Byte address of the read request |
| rspDataIn | input | 32 | Read data returned by the bus |
| rspDataOut | output | 32 | Read data passed on to the self-test engine |

## Verification
Response words of all zeros, all ones and an alternating pattern are used. These separate a forced 1 from a forced 0 and show a stuck value that equals the existing bit causing no change. Request addresses are chosen on and just off the match word, inside and outside masked positions, and above the 24-bit mask reach. This tells an exact compare apart from a masked one and shows the zero-extended top bits are still compared. Directed sequences toggle the enable around configuration writes and reset to separate blocked writes, address capture and configuration retention.

// File: rtl/fi_pkg.sv
package fi_pkg;
  parameter int DATA_W = 32;
  parameter int ADDR_W = 32;
  parameter int MASK_W = 24;
  parameter int IDX_W  = $clog2(DATA_W);
  parameter int WORD_W = ADDR_W - 2;

  // control word, bit 0 upward: alwaysMatch, stuckOne, bitIdx, mask
  typedef struct packed {
    logic [MASK_W-1:0] mask;
    logic [IDX_W-1:0]  bitIdx;
    logic              stuckOne;
    logic              alwaysMatch;
  } ctrlWord_t;

  localparam int CTRL_W = $bits(ctrlWord_t);

  // strobes from control to the forcing datapath
  typedef struct packed {
    logic             apply;
    logic             stuckOne;
    logic [IDX_W-1:0] bitIdx;
  } injStrobe_t;
endpackage

// File: rtl/fi_addr_match.sv
module fi_addr_match
  import fi_pkg::*;
(
  input  logic [WORD_W-1:0] reqWord,
  input  logic [WORD_W-1:0] matchWord,
  input  logic [MASK_W-1:0] mask,
  output logic              hit
);
  logic [WORD_W-1:0] bitOk;

  for (genvar i = 0; i < WORD_W; i++) begin : gCmp
    if (i < MASK_W) begin : gMasked
      assign bitOk[i] = mask[i] || (reqWord[i] == matchWord[i]);
    end else begin : gFixed
      assign bitOk[i] = (reqWord[i] == matchWord[i]);
    end
  end

  assign hit = &bitOk;
endmodule

// File: rtl/fi_ctrl.sv
module fi_ctrl
  import fi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              injEnable,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              matchHit,
  output ctrlWord_t         ctrlWord,
  output logic [WORD_W-1:0] matchWord,
  output logic [WORD_W-1:0] reqWord,
  output injStrobe_t        strobe
);
  logic cfgWriteOk;
  logic unusedBits;

  assign cfgWriteOk = cfgWrEn && injEnable;
  assign unusedBits = ^{cfgWrData[DATA_W-1:CTRL_W], cfgWrData[DATA_W-1:WORD_W], reqAddr[1:0]};

  // configuration holds no reset: software clears it before use
  always_ff @(posedge clk) begin
    if (cfgWriteOk && !cfgSel) ctrlWord <= ctrlWord_t'(cfgWrData[CTRL_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (cfgWriteOk && cfgSel) matchWord <= cfgWrData[WORD_W-1:0];
  end

  // request address is held so it lines up with the returned data
  always_ff @(posedge clk) begin
    if (!rstN)         reqWord <= '0;
    else if (reqValid) reqWord <= reqAddr[ADDR_W-1:2];
  end

  always_comb begin
    strobe.apply    = injEnable && (ctrlWord.alwaysMatch || matchHit);
    strobe.stuckOne = ctrlWord.stuckOne;
    strobe.bitIdx   = ctrlWord.bitIdx;
  end
endmodule

// File: rtl/fi_force_path.sv
module fi_force_path
  import fi_pkg::*;
(
  input  injStrobe_t        strobe,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut
);
  for (genvar i = 0; i < DATA_W; i++) begin : gBit
    assign dataOut[i] = (strobe.apply && (strobe.bitIdx == IDX_W'(i))) ? strobe.stuckOne : dataIn[i];
  end
endmodule

// File: rtl/rd_fault_injector.sv
module rd_fault_injector
  import fi_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              injEnable,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [DATA_W-1:0] cfgWrData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] rspDataIn,
  output logic [DATA_W-1:0] rspDataOut
);
  ctrlWord_t         ctrlWord;
  logic [WORD_W-1:0] matchWord;
  logic [WORD_W-1:0] reqWord;
  logic              matchHit;
  injStrobe_t        strobe;

  fi_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .injEnable(injEnable), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgWrData(cfgWrData), .reqValid(reqValid),
    .reqAddr(reqAddr), .matchHit(matchHit), .ctrlWord(ctrlWord),
    .matchWord(matchWord), .reqWord(reqWord), .strobe(strobe)
  );

  fi_addr_match uMatch (
    .reqWord(reqWord), .matchWord(matchWord), .mask(ctrlWord.mask), .hit(matchHit)
  );

  fi_force_path uForce (
    .strobe(strobe), .dataIn(rspDataIn), .dataOut(rspDataOut)
  );
endmodule

// File: rtl/rd_fault_injector_chk.sv
module rd_fault_injector_chk
  import fi_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              injEnable,
  input logic              cfgWrEn,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [DATA_W-1:0] rspDataIn,
  input logic [DATA_W-1:0] rspDataOut,
  input ctrlWord_t         ctrlWord,
  input logic [WORD_W-1:0] matchWord,
  input logic [WORD_W-1:0] reqWord
);
  assert_passthrough_R1: assert property (@(posedge clk) disable iff (!rstN)
    !injEnable |-> rspDataOut == rspDataIn);

  assert_always_forces_R2: assert property (@(posedge clk) disable iff (!rstN)
    (injEnable && ctrlWord.alwaysMatch) |-> rspDataOut[ctrlWord.bitIdx] == ctrlWord.stuckOne);

  assert_single_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    $countones(rspDataOut ^ rspDataIn) <= 1);

  assert_other_bits_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((rspDataOut ^ rspDataIn) & ~(DATA_W'(1) << ctrlWord.bitIdx)) == '0);

  assert_write_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWrEn && !injEnable) |=> ($stable(ctrlWord) && $stable(matchWord)));

  assert_capture_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> reqWord == $past(reqAddr[ADDR_W-1:2]));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!reqValid && $past(rstN)) |=> $stable(reqWord));
endmodule

bind rd_fault_injector rd_fault_injector_chk uChk (
  .clk(clk), .rstN(rstN), .injEnable(injEnable), .cfgWrEn(cfgWrEn),
  .reqValid(reqValid), .reqAddr(reqAddr), .rspDataIn(rspDataIn),
  .rspDataOut(rspDataOut), .ctrlWord(ctrlWord), .matchWord(matchWord),
  .reqWord(reqWord)
);

// File: tb/rd_fault_injector_test.sv
`timescale 1ns/1ps
module rd_fault_injector_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        injEnable = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [31:0] rspDataIn = '0;
  logic [31:0] rspDataOut;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  rd_fault_injector uut (
    .clk(clk), .rstN(rstN), .injEnable(injEnable), .cfgWrEn(cfgWrEn),
    .cfgSel(cfgSel), .cfgWrData(cfgWrData), .reqValid(reqValid),
    .reqAddr(reqAddr), .rspDataIn(rspDataIn), .rspDataOut(rspDataOut)
  );

  typedef struct packed {
    logic        always1;
    logic        typ;
    logic [4:0]  idx;
    logic [23:0] mask;
    logic [29:0] waddr;
    logic [31:0] req;
    logic [31:0] din;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 5'd0,  24'h0,      30'h0,       32'h1234_5678, 32'h0000_0000, 32'h0000_0001}, // R2 any address
    '{1'b0, 1'b1, 5'd31, 24'h0,      30'h100,     32'h0000_0400, 32'h0000_0000, 32'h8000_0000}, // R3 exact hit
    '{1'b0, 1'b1, 5'd31, 24'h0,      30'h100,     32'h0000_0404, 32'h0000_0000, 32'h0000_0000}, // R3 miss
    '{1'b0, 1'b0, 5'd4,  24'h0,      30'h100,     32'h0000_0400, 32'hFFFF_FFFF, 32'hFFFF_FFEF}, // R5 stuck-at-0
    '{1'b0, 1'b1, 5'd4,  24'h0,      30'h100,     32'h0000_0400, 32'hFFFF_FFFF, 32'hFFFF_FFFF}, // R5 stuck-at-1 on a 1
    '{1'b0, 1'b1, 5'd7,  24'h3,      30'h100,     32'h0000_040C, 32'h0000_0000, 32'h0000_0080}, // R4 masked don't-care
    '{1'b0, 1'b1, 5'd7,  24'h3,      30'h100,     32'h0000_0410, 32'h0000_0000, 32'h0000_0000}, // R4 unmasked bit differs
    '{1'b0, 1'b1, 5'd9,  24'hFF_FFFF, 30'h0,      32'h0400_0000, 32'h0000_0000, 32'h0000_0000}, // R4 top bits compared
    '{1'b0, 1'b1, 5'd9,  24'hFF_FFFF, 30'h0,      32'h03FF_FFFC, 32'h0000_0000, 32'h0000_0200}, // R4 full mask reach
    '{1'b1, 1'b0, 5'd2,  24'h0,      30'h0,       32'h0000_0000, 32'hA5A5_A5A5, 32'hA5A5_A5A1}  // R6 other bits kept
  };

  function automatic logic [31:0] ctrlOf(logic a, logic t, logic [4:0] i, logic [23:0] m);
    return {1'b0, m, i, t, a};
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic writeCfg(logic sel, logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic issueReq(logic [31:0] addr);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic sample(string tag, logic [31:0] din, logic [31:0] exp);
    rspDataIn = din;
    #1;
    check(tag, rspDataOut, exp);
  endtask

  initial begin
    #400_000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    sample("R1 reset passthrough", 32'h5A5A_0F0F, 32'h5A5A_0F0F);
    rstN = 1'b1;

    injEnable = 1'b1;
    writeCfg(1'b0, 32'h0);
    writeCfg(1'b1, 32'h0);

    for (int k = 0; k < NV; k++) begin
      writeCfg(1'b0, ctrlOf(VEC[k].always1, VEC[k].typ, VEC[k].idx, VEC[k].mask));
      writeCfg(1'b1, {2'b00, VEC[k].waddr});
      issueReq(VEC[k].req);
      sample($sformatf("vector %0d", k), VEC[k].din, VEC[k].exp);
    end

    // R1: configured to force but disabled
    writeCfg(1'b0, ctrlOf(1'b1, 1'b1, 5'd0, 24'h0));
    injEnable = 1'b0;
    sample("R1 disabled passthrough", 32'h0, 32'h0);

    // R7: writes while disabled are dropped
    writeCfg(1'b0, ctrlOf(1'b1, 1'b0, 5'd5, 24'h0));
    writeCfg(1'b1, 32'h0000_0155);
    injEnable = 1'b1;
    #1;
    sample("R7 control write ignored", 32'h0000_0020, 32'h0000_0021);

    // R8: captured address held while reqAddr moves
    writeCfg(1'b0, ctrlOf(1'b0, 1'b1, 5'd3, 24'h0));
    writeCfg(1'b1, 32'h0000_0100);
    issueReq(32'h0000_0400);
    reqAddr = 32'h0000_0800;
    repeat (2) @(negedge clk);
    sample("R8 held address", 32'h0, 32'h0000_0008);

    // R8: reset clears the capture; R9: configuration survives reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    sample("R8 capture cleared by reset", 32'h0, 32'h0);
    issueReq(32'h0000_0400);
    sample("R9 config kept through reset", 32'h0, 32'h0000_0008);

    // R3: miss in the top always-compared bits on an otherwise equal word
    issueReq(32'h8000_0400);
    sample("R3 high bit miss", 32'hFFFF_FFF7, 32'hFFFF_FFF7);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule